// File: doc/BRIEF.md
# ADC Conversion Sequencer with Averaging

This block is a register-mapped front end for an external successive-approximation ADC core. Software programs a conversion-clock divider and then writes a command word that names a channel, an averaging exponent and a reference choice. The block then issues one or more conversion requests to the core on the chosen channel. It sums the returned 10-bit samples and divides the sum by the number of samples with a right shift. It stores the average, records it against the channel, and raises an interrupt.

Software clears the interrupt by reading the averaged-result word. The divided conversion clock is built from two 4-bit phase counts. Software splits a total divide N as low = floor(N/2) and high = N - low, so an odd N gets its extra cycle in the high phase. While a sequence runs, a further command that keeps the enable bit set is dropped. A command that clears the enable bit aborts the sequence.

Top module: `adcseq_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, and irq, adc_req and adc_clk are low.
- R2: These registers read back what was written: the clock word bits 7:0 at 0x0C, the eight 32-bit channel control words at 0x10 + 4n, and the 16-bit scan-rate halves at 0x70 (low) and 0x74 (high). Unmapped or unaligned addresses read zero. Read data appears on bus_rdata in the cycle after bus_rd.
- R3: The status word at 0x00 holds bit 0 start, bits 3:1 channel, bit 4 enable, bits 8:5 averaging exponent k and bit 9 internal reference. Bit 0 reads back 1 while a sequence is in progress and 0 otherwise. The channel and the bit 9 value drive adc_chan and adc_vref_int during the sequence.
- R4: With low count L (clock bits 3:0) and high count H (bits 7:4), both nonzero, adc_clk repeats L bus cycles low then H bus cycles high.
- R5: If L or H is zero, adc_clk is held low and a start command does not begin a sequence.
- R6: A status write with bits 0 and 4 set, while idle and with a valid clock, issues exactly 2^k one-cycle adc_req pulses on the selected channel. Each pulse after the first follows the adc_done of the previous one. With k = 0 there is exactly one conversion.
- R7: The averaged result is floor(sum / 2^k). It is read in bits 9:0 of 0x7C, with bits 31:10 zero. Word 0x78 reads zero. The same value is readable in the high word 0x34 + 8n of channel n's data pair, and the low word 0x30 + 8n reads zero.
- R8: irq rises only when a sequence completes. A read of 0x7C clears it in the following cycle.
- R9: While a sequence runs, a status write with bit 4 set is ignored, including its start bit and its fields.
- R10: While a sequence runs, a status write with bit 4 clear aborts it. Busy drops, no further requests are issued and no interrupt is raised.
- R11: A status write with bit 0 set but bit 4 clear starts nothing.
- R12: Writing zero to the status, clock, channel-control and scan-rate registers returns all of them to their reset reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| irq | output | 1 | Conversion-complete interrupt |
| adc_clk | output | 1 | Divided conversion clock |
| adc_req | output | 1 | One-cycle conversion request to the core |
| adc_chan | output | 3 | Channel for the current sequence |
| adc_vref_int | output | 1 | Internal reference select for the current sequence |
| adc_done | input | 1 | Core pulse: a sample is ready |
| adc_data | input | 10 | Sample returned with adc_done |

## Verification
The bound checker watches several rules on every cycle:
- irq rises only right after a sequence finishes.
- A result read drops irq.
- A zero phase count keeps adc_clk low.
- A request never appears outside a sequence.
- An abort command makes the controller idle.
- The result word's upper bits stay zero.

The bench's scenarios show the rest. It sweeps all channels across several averaging exponents and compares the averages with sums computed from the bench's own sample model. It counts requests against 2^k and measures high and low phase lengths for a range of divide counts. It also covers dropped and aborting commands in the middle of a sequence, and restores the idle state by writing zeros.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam int RES_W  = 10;
  localparam int NCH    = 8;
  localparam int CH_W   = $clog2(NCH);
  localparam int AVG_W  = 4;
  localparam int PH_W   = 4;
  localparam int SCAN_W = 16;

  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CLOCK   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CTRL_LO = 8'h10;
  localparam logic [ADDR_W-1:0] A_CTRL_HI = 8'h2C;
  localparam logic [ADDR_W-1:0] A_DATA_LO = 8'h30;
  localparam logic [ADDR_W-1:0] A_DATA_HI = 8'h6C;
  localparam logic [ADDR_W-1:0] A_SCAN_LO = 8'h70;
  localparam logic [ADDR_W-1:0] A_SCAN_HI = 8'h74;
  localparam logic [ADDR_W-1:0] A_AVG_LO  = 8'h78;
  localparam logic [ADDR_W-1:0] A_AVG_HI  = 8'h7C;

  // command fields, bits 9:1 of the status word
  typedef struct packed {
    logic             vref_int;
    logic [AVG_W-1:0] avg_k;
    logic             enable;
    logic [CH_W-1:0]  chan;
  } cmd_t;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} sq_state_t;
endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] lo_cnt,
  input  logic [PH_W-1:0] hi_cnt,
  output logic            cfg_valid,
  output logic            div_clk
);
  logic [PH_W-1:0] cnt_q;
  logic            ph_q;
  logic [PH_W-1:0] lim;

  assign cfg_valid = (lo_cnt != '0) && (hi_cnt != '0);
  assign lim       = ph_q ? (hi_cnt - 1'b1) : (lo_cnt - 1'b1);
  assign div_clk   = ph_q;

  always_ff @(posedge clk) begin
    if (rst || !cfg_valid) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q >= lim) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adcseq_seq.sv
module adcseq_seq
  import adcseq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int AVG_W = 4,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [AVG_W-1:0] cfg_k,
  input  logic             cfg_vref,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_data,
  output logic             busy,
  output logic             fin,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  res_chan,
  output logic             adc_req,
  output logic [CH_W-1:0]  adc_chan,
  output logic             adc_vref_int
);
  localparam int MAXK  = (1 << AVG_W) - 1;
  localparam int ACC_W = RES_W + MAXK;
  localparam int CNT_W = MAXK + 1;

  sq_state_t        st_q;
  logic [ACC_W-1:0] acc_q, sum_d;
  logic [CNT_W-1:0] cnt_q, last_idx;
  logic [AVG_W-1:0] k_q;
  logic             req_q, fin_q, vref_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] res_q;
  logic [ACC_W-1:0] shifted;

  assign sum_d    = acc_q + {{(ACC_W-RES_W){1'b0}}, adc_data};
  assign last_idx = ({{(CNT_W-1){1'b0}}, 1'b1} << k_q) - 1'b1;
  assign shifted  = sum_d >> k_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      acc_q  <= '0;
      cnt_q  <= '0;
      k_q    <= '0;
      req_q  <= 1'b0;
      fin_q  <= 1'b0;
      chan_q <= '0;
      vref_q <= 1'b0;
      res_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      req_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (start) begin
            st_q   <= SQ_RUN;
            acc_q  <= '0;
            cnt_q  <= '0;
            k_q    <= cfg_k;
            chan_q <= cfg_chan;
            vref_q <= cfg_vref;
            req_q  <= 1'b1;
          end
        end
        SQ_RUN: begin
          if (abort) begin
            st_q <= SQ_IDLE;
          end else if (adc_done) begin
            if (cnt_q == last_idx) begin
              st_q  <= SQ_IDLE;
              res_q <= shifted[RES_W-1:0];
              fin_q <= 1'b1;
            end else begin
              acc_q <= sum_d;
              cnt_q <= cnt_q + 1'b1;
              req_q <= 1'b1;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy         = (st_q == SQ_RUN);
  assign fin          = fin_q;
  assign result       = res_q;
  assign res_chan     = chan_q;
  assign adc_req      = req_q;
  assign adc_chan     = chan_q;
  assign adc_vref_int = vref_q;
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int RES_W  = 10,
  parameter int NCH    = 8,
  parameter int CH_W   = 3,
  parameter int PH_W   = 4,
  parameter int SCAN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              clk_valid,
  input  logic              fin,
  input  logic [RES_W-1:0]  result,
  input  logic [CH_W-1:0]   res_chan,
  output logic              start,
  output logic              abort,
  output logic [PH_W-1:0]   lo_cnt,
  output logic [PH_W-1:0]   hi_cnt,
  output logic              irq
);
  localparam int CMD_W = $bits(cmd_t);

  cmd_t              cmd_q, cmd_in;
  logic [2*PH_W-1:0] clkw_q;
  logic [BUS_W-1:0]  ctrl_q [NCH];
  logic [RES_W-1:0]  chdat_q [NCH];
  logic [SCAN_W-1:0] scan_lo_q, scan_hi_q;
  logic              irq_q;
  logic [BUS_W-1:0]  rd_mux;

  logic              wr_stat, in_ctrl, in_data, aligned;
  logic [ADDR_W-1:0] ctrl_off, data_off;
  logic [CH_W-1:0]   ctrl_idx, data_idx;

  assign cmd_in   = cmd_t'(bus_wdata[CMD_W:1]);
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign ctrl_off = bus_addr - A_CTRL_LO;
  assign data_off = bus_addr - A_DATA_LO;
  assign ctrl_idx = ctrl_off[CH_W+1:2];
  assign data_idx = data_off[CH_W+2:3];
  assign in_ctrl  = aligned && (bus_addr >= A_CTRL_LO) && (bus_addr <= A_CTRL_HI);
  assign in_data  = aligned && (bus_addr >= A_DATA_LO) && (bus_addr <= A_DATA_HI);
  assign wr_stat  = bus_wr && (bus_addr == A_STATUS);

  assign start  = wr_stat && !busy && bus_wdata[0] && cmd_in.enable && clk_valid;
  assign abort  = wr_stat && busy && !cmd_in.enable;
  assign lo_cnt = clkw_q[PH_W-1:0];
  assign hi_cnt = clkw_q[2*PH_W-1:PH_W];
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      clkw_q    <= '0;
      scan_lo_q <= '0;
      scan_hi_q <= '0;
      for (int i = 0; i < NCH; i++) ctrl_q[i] <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_STATUS) begin
        if (!busy || !cmd_in.enable) cmd_q <= cmd_in;
      end
      if (bus_addr == A_CLOCK)   clkw_q    <= bus_wdata[2*PH_W-1:0];
      if (bus_addr == A_SCAN_LO) scan_lo_q <= bus_wdata[SCAN_W-1:0];
      if (bus_addr == A_SCAN_HI) scan_hi_q <= bus_wdata[SCAN_W-1:0];
      if (in_ctrl)               ctrl_q[ctrl_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) chdat_q[i] <= '0;
    end else if (fin) begin
      chdat_q[res_chan] <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  irq_q <= 1'b0;
    else if (fin)                             irq_q <= 1'b1;
    else if (bus_rd && bus_addr == A_AVG_HI)  irq_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_STATUS)
      rd_mux = {{(BUS_W-CMD_W-1){1'b0}}, cmd_q, busy};
    else if (bus_addr == A_CLOCK)
      rd_mux = {{(BUS_W-2*PH_W){1'b0}}, clkw_q};
    else if (bus_addr == A_SCAN_LO)
      rd_mux = {{(BUS_W-SCAN_W){1'b0}}, scan_lo_q};
    else if (bus_addr == A_SCAN_HI)
      rd_mux = {{(BUS_W-SCAN_W){1'b0}}, scan_hi_q};
    else if (bus_addr == A_AVG_HI)
      rd_mux = {{(BUS_W-RES_W){1'b0}}, result};
    else if (in_ctrl)
      rd_mux = ctrl_q[ctrl_idx];
    else if (in_data && data_off[2])
      rd_mux = {{(BUS_W-RES_W){1'b0}}, chdat_q[data_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = adcseq_pkg::ADDR_W,
  parameter int BUS_W  = adcseq_pkg::BUS_W,
  parameter int RES_W  = adcseq_pkg::RES_W,
  parameter int NCH    = adcseq_pkg::NCH,
  parameter int AVG_W  = adcseq_pkg::AVG_W,
  parameter int PH_W   = adcseq_pkg::PH_W,
  parameter int SCAN_W = adcseq_pkg::SCAN_W,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              adc_clk,
  output logic              adc_req,
  output logic [CH_W-1:0]   adc_chan,
  output logic              adc_vref_int,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_data
);
  logic             busy, fin, clk_valid, start, abort;
  logic [RES_W-1:0] result;
  logic [CH_W-1:0]  res_chan;
  logic [PH_W-1:0]  lo_cnt, hi_cnt;
  cmd_t             cmd_in;

  assign cmd_in = cmd_t'(bus_wdata[$bits(cmd_t):1]);

  adcseq_regs #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .RES_W(RES_W), .NCH(NCH),
    .CH_W(CH_W), .PH_W(PH_W), .SCAN_W(SCAN_W)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .clk_valid(clk_valid), .fin(fin), .result(result),
    .res_chan(res_chan), .start(start), .abort(abort),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .irq(irq)
  );

  adcseq_clkdiv #(.PH_W(PH_W)) div_i (
    .clk(clk), .rst(rst), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .cfg_valid(clk_valid), .div_clk(adc_clk)
  );

  adcseq_seq #(.RES_W(RES_W), .AVG_W(AVG_W), .CH_W(CH_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .cfg_chan(cmd_in.chan), .cfg_k(cmd_in.avg_k), .cfg_vref(cmd_in.vref_int),
    .adc_done(adc_done), .adc_data(adc_data), .busy(busy), .fin(fin),
    .result(result), .res_chan(res_chan), .adc_req(adc_req),
    .adc_chan(adc_chan), .adc_vref_int(adc_vref_int)
  );
endmodule

// File: rtl/adcseq_ctrl_chk.sv
module adcseq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int RES_W  = 10,
  parameter int PH_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq,
  input logic              adc_clk,
  input logic              adc_req,
  input logic              busy,
  input logic              fin,
  input logic [PH_W-1:0]   lo_cnt,
  input logic [PH_W-1:0]   hi_cnt
);
  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(fin));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h7C && !fin) |=> !irq);

  // R5
  clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt == '0 || hi_cnt == '0) |=> !adc_clk);

  // R6
  req_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    adc_req |-> busy);

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 8'h00 && !bus_wdata[4] && busy) |=> !busy);

  // R7
  res_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 8'h7C) |=> (bus_rdata[BUS_W-1:RES_W] == '0));
endmodule

bind adcseq_ctrl adcseq_ctrl_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .RES_W(RES_W), .PH_W(PH_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .adc_clk(adc_clk), .adc_req(adc_req), .busy(busy),
  .fin(fin), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
);

// File: tb/adcseq_ctrl_tb_top.sv
module adcseq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, adc_clk, adc_req, adc_vref_int;
  logic [2:0]  adc_chan;
  logic        adc_done;
  logic [9:0]  adc_data;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .adc_clk(adc_clk), .adc_req(adc_req), .adc_chan(adc_chan),
    .adc_vref_int(adc_vref_int), .adc_done(adc_done), .adc_data(adc_data)
  );

  function automatic logic [9:0] sample(int ch, int g);
    return 10'((ch * 131 + g * 211 + 700) % 1024);
  endfunction

  // ADC core model: each request gets a sample LAT+1 cycles later
  int         req_cnt = 0;
  logic       pend = 1'b0;
  int         lat = 0;
  logic [9:0] pend_val = '0;
  always @(posedge clk) begin
    if (rst) begin
      adc_done <= 1'b0; adc_data <= '0; pend <= 1'b0; lat <= 0;
    end else begin
      adc_done <= 1'b0;
      if (adc_req) begin
        pend <= 1'b1; lat <= LAT;
        pend_val <= sample(int'(adc_chan), req_cnt);
        req_cnt <= req_cnt + 1;
      end else if (pend) begin
        if (lat == 0) begin
          adc_done <= 1'b1; adc_data <= pend_val; pend <= 1'b0;
        end else lat <= lat - 1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [31:0] cmd(int start, int ch, int en, int k, int vref);
    return 32'((start & 1) | ((ch & 7) << 1) | ((en & 1) << 4) | ((k & 15) << 5) | ((vref & 1) << 9));
  endfunction

  task automatic wait_irq(output int ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic measure(int n);
    int lo_e, hi_e, h, l;
    lo_e = n / 2; hi_e = n - lo_e;
    wr(8'h0C, 32'((hi_e << 4) | lo_e));
    repeat (40) @(negedge clk);
    while (adc_clk) @(negedge clk);
    while (!adc_clk) @(negedge clk);
    h = 0; l = 0;
    while (adc_clk) begin h++; @(negedge clk); end
    while (!adc_clk) begin l++; @(negedge clk); end
    chk($sformatf("R4 high phase N=%0d", n), 32'(h), 32'(hi_e));
    chk($sformatf("R4 low phase N=%0d", n), 32'(l), 32'(lo_e));
  endtask

  task automatic run_conv(int ch, int k, int vref);
    logic [31:0] d;
    int g0, ok, sum, expv;
    g0 = req_cnt;
    wr(8'h00, cmd(1, ch, 1, k, vref));
    rd(8'h00, d);
    chk("R3 busy readback", d[0], 1);
    chk("R3 chan output", 32'(adc_chan), 32'(ch));
    chk("R3 vref output", 32'(adc_vref_int), 32'(vref));
    wait_irq(ok);
    chk("R8 irq raised", 32'(ok), 1);
    sum = 0;
    for (int i = 0; i < (1 << k); i++) sum += int'(sample(ch, g0 + i));
    expv = sum >> k;
    chk($sformatf("R6 requests ch%0d k%0d", ch, k), 32'(req_cnt - g0), 32'(1 << k));
    rd(8'h78, d); chk("R7 low word zero", d, 0);
    rd(8'h7C, d); chk($sformatf("R7 average ch%0d k%0d", ch, k), d, 32'(expv));
    chk("R8 irq cleared", 32'(irq), 0);
    rd(8'h34 + 8'(8 * ch), d); chk("R7 channel data high", d, 32'(expv));
    rd(8'h30 + 8'(8 * ch), d); chk("R7 channel data low", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int g0, ok, sum;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 adc_req", 32'(adc_req), 0);
    chk("R1 adc_clk", 32'(adc_clk), 0);
    for (int a = 0; a < 8'h80; a += 4) begin
      rd(8'(a), d); chk($sformatf("R1 reg %0h", a), d, 0);
    end
    // R2 readback
    wr(8'h0C, 32'hFFFF_FFA5); rd(8'h0C, d); chk("R2 clock", d, 32'hA5);
    for (int n = 0; n < 8; n++) wr(8'(8'h10 + 4 * n), 32'hC0DE_0000 + 32'(n * 4099));
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h10 + 4 * n), d); chk("R2 ctrl", d, 32'hC0DE_0000 + 32'(n * 4099));
    end
    wr(8'h70, 32'h1234_5678); rd(8'h70, d); chk("R2 scan low", d, 32'h5678);
    wr(8'h74, 32'h9ABC_DEF0); rd(8'h74, d); chk("R2 scan high", d, 32'hDEF0);
    rd(8'h11, d); chk("R2 unaligned", d, 0);
    rd(8'hF0, d); chk("R2 unmapped", d, 0);
    // R4 divider sweep
    for (int n = 2; n <= 30; n += 1) if (n <= 16 || n % 7 == 2) measure(n);
    // R5 invalid clock
    wr(8'h0C, 32'h50);
    repeat (5) @(negedge clk);
    begin
      int seen = 0;
      g0 = req_cnt;
      wr(8'h00, cmd(1, 3, 1, 0, 0));
      for (int i = 0; i < 40; i++) begin @(negedge clk); seen |= int'(adc_clk); end
      chk("R5 clock held low", 32'(seen), 0);
      chk("R5 start blocked", 32'(req_cnt - g0), 0);
      rd(8'h00, d); chk("R5 not busy", d[0], 0);
      chk("R5 no irq", 32'(irq), 0);
    end
    wr(8'h0C, 32'h43);
    // R11 enable clear
    g0 = req_cnt;
    wr(8'h00, cmd(1, 2, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk("R11 no request", 32'(req_cnt - g0), 0);
    chk("R11 no irq", 32'(irq), 0);
    // R6 R7 R8 sweep
    for (int k = 0; k <= 5; k++)
      for (int ch = 0; ch < 8; ch++)
        if (k <= 2 || ch == k) run_conv(ch, k, (ch + k) & 1);
    // R9 ignored command while busy
    g0 = req_cnt;
    wr(8'h00, cmd(1, 2, 1, 3, 0));
    repeat (4) @(negedge clk);
    wr(8'h00, cmd(1, 5, 1, 0, 1));
    chk("R9 chan kept", 32'(adc_chan), 2);
    rd(8'h00, d); chk("R9 fields kept", d, cmd(1, 2, 1, 3, 0));
    wait_irq(ok);
    sum = 0;
    for (int i = 0; i < 8; i++) sum += int'(sample(2, g0 + i));
    chk("R9 request count", 32'(req_cnt - g0), 8);
    rd(8'h7C, d); chk("R9 average unchanged", d, 32'(sum >> 3));
    // R10 abort
    g0 = req_cnt;
    wr(8'h00, cmd(1, 6, 1, 4, 0));
    repeat (12) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R10 idle", d, 0);
    begin
      int n0;
      n0 = req_cnt;
      repeat (60) @(negedge clk);
      chk("R10 no more requests", 32'(req_cnt - n0), 0);
      chk("R10 no irq", 32'(irq), 0);
      chk("R10 stopped early", 32'(req_cnt - g0 < 16), 1);
    end
    // R12 zero writes
    wr(8'h00, 0); wr(8'h0C, 0); wr(8'h70, 0); wr(8'h74, 0);
    for (int n = 0; n < 8; n++) wr(8'(8'h10 + 4 * n), 0);
    rd(8'h00, d); chk("R12 status", d, 0);
    rd(8'h0C, d); chk("R12 clock", d, 0);
    rd(8'h70, d); chk("R12 scan low", d, 0);
    rd(8'h74, d); chk("R12 scan high", d, 0);
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h10 + 4 * n), d); chk("R12 ctrl", d, 0);
    end
    repeat (4) @(negedge clk);
    chk("R12 clock low", 32'(adc_clk), 0);
    chk("R12 irq low", 32'(irq), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule